// File: doc/BRIEF.md
# Video Stream Pixel Position Tagger

This block sits in line with a video stream that follows the AXI4-Stream handshake. It passes every beat through unchanged, with one register stage. Each beat that leaves carries the pixel column and the line number that the beat holds within the frame. A beat is taken from the input when the input valid and the ready are high together. The user sideband bit marks the first pixel of a frame. The last sideband bit marks the final pixel of a line. Downstream logic such as overlay, cropping or statistics can then read the position of each pixel directly, without keeping its own counters.

The position counters are registered state, and they change only on an accepted beat. Ready is not buffered: the downstream ready goes straight back to the upstream side. The output register loads whenever the downstream side is ready. Beats that arrive before the first start of frame still pass through, but their tags are marked as not belonging to a frame. Neither counter wraps. When a line or a frame runs longer than the counter range, the counter stays at its top value.

Top module: `vtag_tracker`

## Requirements
- R1: After synchronous reset, `m_tvalid` is 0, and the first beat accepted without `s_tuser` is tagged column 0, line 0, in-frame 0.
- R2: `s_tready` equals `m_tready` in every cycle.
- R3: While `m_tvalid` is 1 and `m_tready` is 0, every output holds its value into the next cycle.
- R4: An accepted beat with `s_tuser` = 1 is tagged column 0, line 0, in-frame 1. The next accepted beat after it, if the first had `s_tlast` = 0, is tagged column 1, line 0.
- R5: An accepted beat with `s_tuser` = 0 and `s_tlast` = 0 makes the next beat's column one higher, with the line unchanged.
- R6: An accepted beat with `s_tuser` = 0 and `s_tlast` = 1 makes the next beat's column 0 and its line one higher.
- R7: An accepted beat with `s_tuser` and `s_tlast` both 1 is tagged column 0, line 0. The next beat is tagged column 0, line 1.
- R8: A cycle without an accepted beat (either `s_tvalid` or `m_tready` low) leaves the column and line of the next accepted beat unchanged.
- R9: The column stays at 2^COL_W-1 and the line at 2^LINE_W-1 instead of wrapping.
- R10: A beat accepted at a clock edge appears right after that edge on `m_tdata`, `m_tuser` and `m_tlast`, together with its tags and `m_tvalid` = 1. After an edge where `m_tready` = 1 and `s_tvalid` = 0, `m_tvalid` is 0.
- R11: `m_in_frame` is 0 for beats before the first `s_tuser` beat after reset, and 1 for every beat from that one on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | DATA_W | Input pixel data |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input ready (copy of `m_tready`) |
| s_tuser | input | 1 | Start of frame marker |
| s_tlast | input | 1 | End of line marker |
| m_tdata | output | DATA_W | Registered pixel data |
| m_tvalid | output | 1 | Output beat valid; also qualifies the tags |
| m_tready | input | 1 | Downstream ready |
| m_tuser | output | 1 | Registered start of frame marker |
| m_tlast | output | 1 | Registered end of line marker |
| m_col | output | COL_W | Column index of the output beat |
| m_line | output | LINE_W | Line index of the output beat |
| m_in_frame | output | 1 | Output beat belongs to a frame that has started |

## Verification
The assertions assume that reset is held high for at least one clock at start-up. They also assume that every input has a known value at each clock edge, because the counter properties key on the accept, start and end-of-line terms. The stimulus drives every input from time zero and changes inputs only just after a clock edge. The bench model updates its expected column and line only on cycles where both valid and ready were high at the edge, so it never steps the counters on a stalled cycle.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

  // Saturating step: one above v, but never above lim.
  function automatic int unsigned bump_sat(input int unsigned v, input int unsigned lim);
    if (v >= lim) return lim;
    return v + 32'd1;
  endfunction

  // Column of the beat after an accepted one.
  function automatic int unsigned next_col(input logic sof, input logic eol,
                                           input int unsigned col, input int unsigned lim);
    if (eol) return 32'd0;
    if (sof) return 32'd1;
    return bump_sat(col, lim);
  endfunction

  // Line of the beat after an accepted one.
  function automatic int unsigned next_line(input logic sof, input logic eol,
                                            input int unsigned line, input int unsigned lim);
    if (sof) return eol ? 32'd1 : 32'd0;
    if (eol) return bump_sat(line, lim);
    return line;
  endfunction

endpackage

// File: rtl/vtag_pos_track.sv
module vtag_pos_track
  import vtag_pkg::*;
#(
  parameter int COL_W  = 12,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sof,
  input  logic              eol,
  output logic [COL_W-1:0]  tag_col,
  output logic [LINE_W-1:0] tag_line,
  output logic              tag_in_frame
);
  localparam int unsigned COL_MAX  = (32'd1 << COL_W) - 32'd1;
  localparam int unsigned LINE_MAX = (32'd1 << LINE_W) - 32'd1;

  logic [COL_W-1:0]  col_q, col_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              frame_q;

  // The start-of-frame beat is tagged at the origin, whatever the counters hold.
  always_comb begin
    tag_col      = sof ? '0 : col_q;
    tag_line     = sof ? '0 : line_q;
    tag_in_frame = sof | frame_q;
    col_d  = COL_W'(next_col(sof, eol, 32'(col_q), COL_MAX));
    line_d = LINE_W'(next_line(sof, eol, 32'(line_q), LINE_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q   <= '0;
      line_q  <= '0;
      frame_q <= 1'b0;
    end else if (accept) begin
      col_q   <= col_d;
      line_q  <= line_d;
      frame_q <= frame_q | sof;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(col_q) && $stable(line_q)));

  assert_sof_origin_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && sof && !eol) |=> (col_q == COL_W'(1) && line_q == '0));

  assert_sof_eol_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && sof && eol) |=> (col_q == '0 && line_q == LINE_W'(1)));

  assert_eol_step_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && !sof && eol && line_q != LINE_W'(LINE_MAX))
      |=> (col_q == '0 && line_q == LINE_W'($past(line_q) + 1'b1)));

  assert_col_sat_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && !sof && !eol && col_q == COL_W'(COL_MAX)) |=> (col_q == COL_W'(COL_MAX)));

  assert_frame_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    frame_q |=> frame_q);

endmodule

// File: rtl/vtag_out_reg.sv
module vtag_out_reg #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 12,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_user,
  input  logic              in_last,
  input  logic [COL_W-1:0]  in_col,
  input  logic [LINE_W-1:0] in_line,
  input  logic              in_frame,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_user,
  output logic              out_last,
  output logic [COL_W-1:0]  out_col,
  output logic [LINE_W-1:0] out_line,
  output logic              out_frame
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_user  <= 1'b0;
      out_last  <= 1'b0;
      out_col   <= '0;
      out_line  <= '0;
      out_frame <= 1'b0;
    end else if (load_en) begin
      out_valid <= in_valid;
      out_data  <= in_data;
      out_user  <= in_user;
      out_last  <= in_last;
      out_col   <= in_col;
      out_line  <= in_line;
      out_frame <= in_frame;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !load_en) |=> (out_valid && $stable(out_data) && $stable(out_col)
                                 && $stable(out_line) && $stable(out_user)
                                 && $stable(out_last) && $stable(out_frame)));

  assert_load_R10: assert property (@(posedge clk) disable iff (rst)
    (load_en && in_valid) |=> (out_valid && out_data == $past(in_data)));

endmodule

// File: rtl/vtag_tracker.sv
module vtag_tracker #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 12,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tuser,
  input  logic              s_tlast,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tuser,
  output logic              m_tlast,
  output logic [COL_W-1:0]  m_col,
  output logic [LINE_W-1:0] m_line,
  output logic              m_in_frame
);
  logic              beat_accept;
  logic [COL_W-1:0]  cur_col;
  logic [LINE_W-1:0] cur_line;
  logic              cur_in_frame;

  assign s_tready    = m_tready;
  assign beat_accept = s_tvalid & m_tready;

  vtag_pos_track #(.COL_W(COL_W), .LINE_W(LINE_W)) u_track (
    .clk          (clk),
    .rst          (rst),
    .accept       (beat_accept),
    .sof          (s_tuser),
    .eol          (s_tlast),
    .tag_col      (cur_col),
    .tag_line     (cur_line),
    .tag_in_frame (cur_in_frame)
  );

  vtag_out_reg #(.DATA_W(DATA_W), .COL_W(COL_W), .LINE_W(LINE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load_en   (m_tready),
    .in_valid  (s_tvalid),
    .in_data   (s_tdata),
    .in_user   (s_tuser),
    .in_last   (s_tlast),
    .in_col    (cur_col),
    .in_line   (cur_line),
    .in_frame  (cur_in_frame),
    .out_valid (m_tvalid),
    .out_data  (m_tdata),
    .out_user  (m_tuser),
    .out_last  (m_tlast),
    .out_col   (m_col),
    .out_line  (m_line),
    .out_frame (m_in_frame)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> !m_tvalid);

  assert_sof_tag_R4: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tuser) |-> (m_col == '0 && m_line == '0 && m_in_frame));

endmodule

// File: tb/vtag_tracker_tb.sv
module vtag_tracker_tb;
  localparam int DW = 8;
  localparam int CW = 12;
  localparam int LW = 12;
  localparam int CMAX = (1 << CW) - 1;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0, m_tready = 1'b1;
  logic s_tready, m_tvalid, m_tuser, m_tlast, m_in_frame;
  logic [DW-1:0] m_tdata;
  logic [CW-1:0] m_col;
  logic [LW-1:0] m_line;

  int n_tests = 0, n_fail = 0;
  int e_col = 0, e_line = 0, e_frame = 0;

  always #5 clk = ~clk;

  vtag_tracker #(.DATA_W(DW), .COL_W(CW), .LINE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tuser(s_tuser), .s_tlast(s_tlast), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast), .m_col(m_col),
    .m_line(m_line), .m_in_frame(m_in_frame));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Sends one accepted beat and checks it at the output right after the edge.
  task automatic beat(input logic [DW-1:0] d, input logic u, input logic l, input string req);
    int tc, tl, tf;
    @(negedge clk);
    s_tdata = d; s_tuser = u; s_tlast = l; s_tvalid = 1'b1; m_tready = 1'b1;
    @(posedge clk); #1;
    s_tvalid = 1'b0;
    tc = u ? 0 : e_col;
    tl = u ? 0 : e_line;
    tf = (u || e_frame != 0) ? 1 : 0;
    if (u) begin e_frame = 1; e_line = l ? 1 : 0; e_col = l ? 0 : 1; end
    else if (l) begin e_col = 0; e_line = (e_line == LMAX) ? LMAX : e_line + 1; end
    else e_col = (e_col == CMAX) ? CMAX : e_col + 1;
    check(m_tvalid === 1'b1, {req, " valid"}, int'(m_tvalid), 1);
    check(m_col == CW'(tc), {req, " col"}, int'(m_col), tc);
    check(m_line == LW'(tl), {req, " line"}, int'(m_line), tl);
    check(m_in_frame == tf[0], {req, " in_frame"}, int'(m_in_frame), tf);
    check(m_tdata == d && m_tuser == u && m_tlast == l, {req, " R10 data"}, int'(m_tdata), int'(d));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check(m_tvalid == 1'b0, "R1 valid after reset", int'(m_tvalid), 0);
  endtask

  task automatic t_preframe();
    beat(8'h11, 0, 0, "R1 R11 first");
    beat(8'h12, 0, 0, "R11 R5 second");
  endtask

  task automatic t_ready_path();
    @(negedge clk); m_tready = 1'b0; #1;
    check(s_tready == 1'b0, "R2 ready low", int'(s_tready), 0);
    m_tready = 1'b1; #1;
    check(s_tready == 1'b1, "R2 ready high", int'(s_tready), 1);
  endtask

  task automatic t_frame();
    beat(8'h20, 1, 0, "R4 sof");
    beat(8'h21, 0, 0, "R4 R5 col1");
    beat(8'h22, 0, 0, "R5 col2");
    beat(8'h23, 0, 1, "R6 eol");
    beat(8'h24, 0, 0, "R6 line1");
    beat(8'h25, 0, 1, "R6 eol2");
    beat(8'h26, 0, 0, "R6 line2");
  endtask

  task automatic t_idle_stall();
    @(posedge clk); #1;
    check(m_tvalid == 1'b0, "R10 idle valid", int'(m_tvalid), 0);
    repeat (3) @(posedge clk);
    beat(8'h30, 0, 0, "R8 after idle");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    m_tready = 1'b0; s_tvalid = 1'b1; s_tdata = 8'h41; s_tuser = 1'b0; s_tlast = 1'b0;
    repeat (3) begin
      @(posedge clk); #1;
      check(m_tvalid == 1'b1 && m_tdata == 8'h30, "R3 hold data", int'(m_tdata), 'h30);
      check(s_tready == 1'b0, "R2 stalled ready", int'(s_tready), 0);
    end
    s_tvalid = 1'b0;
    beat(8'h41, 0, 0, "R8 after backpressure");
  endtask

  task automatic t_sof_eol();
    beat(8'h50, 1, 1, "R7 sof+eol");
    beat(8'h51, 0, 0, "R7 next");
    beat(8'h52, 1, 0, "R4 mid-line restart");
    beat(8'h53, 0, 0, "R4 col1 again");
  endtask

  task automatic t_col_sat();
    beat(8'h60, 1, 0, "R9 col sof");
    for (int i = 0; i < CMAX + 3; i++) beat(8'(i), 0, 0, "R9 col run");
    check(m_col == CW'(CMAX), "R9 col top", int'(m_col), CMAX);
  endtask

  task automatic t_line_sat();
    beat(8'h70, 1, 1, "R9 line sof");
    for (int i = 0; i < LMAX + 3; i++) beat(8'(i), 0, 1, "R9 line run");
    check(m_line == LW'(LMAX), "R9 line top", int'(m_line), LMAX);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_preframe();
    t_ready_path();
    t_frame();
    t_idle_stall();
    t_backpressure();
    t_sof_eol();
    t_col_sat();
    t_line_sat();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule